// File: doc/BRIEF.md
# Message-Signalled Interrupt Translation Table

This block sits behind the inbound write path of a PCIe root port. It turns message-signalled interrupt writes into pulses on a few shared interrupt lines. Software programs a table of up to sixteen 32-bit entries through a simple register port. Each entry holds four things: a disable flag, a 12-bit address key, a 16-bit expected data word (normally one-hot, bit n for entry n) and a 2-bit selector for one of four output lines.

When a message arrives, it is checked against every entry at once. The address key is compared with message address bits 23:12. The data word is compared with the message data, byte-swapped first when the byte-order control selects big-endian. Each output line is pulsed for one cycle if any enabled entry routed to it matches. A sticky per-line pending register records the hits until software clears them by writing ones.

Top module: `msi_xlat_table`

## Requirements
- R1: After reset, every entry reads 0x8000_0000 (disabled), the byte-order register reads 0, the pending register reads 0 and irq_o is 0.
- R2: Entry n is accessed at byte offset 4*n. A write stores all 32 bits, and a read returns the stored value combinationally for the current reg_addr_i.
- R3: An entry whose bit 31 is 1 never matches any message.
- R4: An entry matches when three things hold: its bit 31 is 0, its bits 27:16 equal msg_addr_i[23:12], and its bits 15:0 equal the (possibly swapped) msg_data_i. A match during a cycle with msg_valid_i high drives irq_o[entry bits 29:28] high for exactly the following cycle.
- R5: The byte-order register is at offset 0x40, bit 0. When it is 1, msg_data_i is compared as {msg_data_i[7:0], msg_data_i[15:8]}. Reads return bit 0 with the upper bits zero.
- R6: When several entries on one line match in the same cycle, that line shows one single-cycle pulse. Matches on different lines pulse their lines in the same cycle.
- R7: The pending register is at offset 0x44, bits 3:0, one bit per line. A bit is set in the same cycle its line pulses. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A hit in the same cycle as a clear leaves the bit set.
- R8: Offsets that are not word-aligned, and aligned offsets other than the entries, 0x40 and 0x44, read as zero. Writes to them change no state.
- R9: A cycle with msg_valid_i low produces no pulse on irq_o in the next cycle.
- R10: A message is compared against the table contents from before any register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write enable |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| msg_valid_i | input | 1 | Message strobe, one message per cycle |
| msg_addr_i | input | 32 | Message write address |
| msg_data_i | input | 16 | Message write data |
| irq_o | output | 4 | Interrupt line pulses |

## Verification
A corrupted entry, flag or key affects the ports only when a message targets that entry. It then shows as a missing or misrouted pulse one cycle after the message. A readback of the entry exposes it at once. A stuck or wrongly swapped byte-order bit misroutes every message with asymmetric data from the next cycle on. A pending bit that is lost or set wrongly stays invisible until the 0x44 register is read. For that reason the bench reads pending after each set and clear, and also after a set and a clear collide in one cycle. The reference model checks irq_o against its own prediction on every clock, so a wrong pulse is reported in the cycle it appears.

// File: rtl/msi_xlat_pkg.sv
package msi_xlat_pkg;
  localparam int ENTRY_W   = 32;
  localparam int KEY_W     = 12;
  localparam int DATA_W    = 16;
  localparam int SEL_W     = 2;
  localparam int DIS_BIT   = 31;
  localparam int SEL_LSB   = 28;
  localparam int KEY_LSB   = 16;
  localparam int MSG_KEY_LSB = 12;
  localparam int REG_AW    = 8;
  localparam logic [REG_AW-1:0] ORDER_OFS = 8'h40;
  localparam logic [REG_AW-1:0] PEND_OFS  = 8'h44;
  localparam logic [ENTRY_W-1:0] ENTRY_RST = 32'h8000_0000;
endpackage

// File: rtl/msi_entry_match.sv
module msi_entry_match
  import msi_xlat_pkg::*;
#(
  parameter int N_LINE = 4
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic               valid_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [N_LINE-1:0]  line_o
);
  logic hit;
  logic unused_rsv;

  assign unused_rsv = entry_i[30];
  assign hit = valid_i && !entry_i[DIS_BIT]
            && (entry_i[KEY_LSB +: KEY_W] == key_i)
            && (entry_i[DATA_W-1:0] == data_i);

  always_comb begin
    line_o = '0;
    for (int l = 0; l < N_LINE; l++) begin
      if (hit && (entry_i[SEL_LSB +: SEL_W] == SEL_W'(l))) line_o[l] = 1'b1;
    end
  end
endmodule

// File: rtl/msi_line_merge.sv
module msi_line_merge #(
  parameter int N_ENTRY = 16,
  parameter int N_LINE  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LINE-1:0] sel_i [N_ENTRY],
  output logic [N_LINE-1:0] hit_o,
  output logic [N_LINE-1:0] irq_o
);
  always_comb begin
    hit_o = '0;
    for (int e = 0; e < N_ENTRY; e++) hit_o |= sel_i[e];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= hit_o;
  end
endmodule

// File: rtl/msi_xlat_regs.sv
module msi_xlat_regs
  import msi_xlat_pkg::*;
#(
  parameter int N_ENTRY = 16,
  parameter int N_LINE  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic               we_i,
  input  logic [N_LINE-1:0]  hit_i,
  output logic [ENTRY_W-1:0] ent_o [N_ENTRY],
  output logic               order_o,
  output logic [N_LINE-1:0]  pend_o,
  output logic [ENTRY_W-1:0] rdata_o
);
  localparam int IDX_W = REG_AW - 2;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              wr_ok;
  logic [N_LINE-1:0] clr;

  assign idx     = addr_i[REG_AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr_ok   = we_i && aligned;

  for (genvar gi = 0; gi < N_ENTRY; gi++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                ent_o[gi] <= ENTRY_RST;
      else if (wr_ok && idx == IDX_W'(gi))        ent_o[gi] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           order_o <= 1'b0;
    else if (we_i && addr_i == ORDER_OFS)  order_o <= wdata_i[0];
  end

  assign clr = (we_i && addr_i == PEND_OFS) ? wdata_i[N_LINE-1:0] : '0;

  // a hit in the clearing cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr) | hit_i;
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      for (int i = 0; i < N_ENTRY; i++) begin
        if (idx == IDX_W'(i)) rdata_o = ent_o[i];
      end
      if (addr_i == ORDER_OFS) rdata_o = {{(ENTRY_W-1){1'b0}}, order_o};
      if (addr_i == PEND_OFS)  rdata_o = {{(ENTRY_W-N_LINE){1'b0}}, pend_o};
    end
  end
endmodule

// File: rtl/msi_xlat_table.sv
module msi_xlat_table
  import msi_xlat_pkg::*;
#(
  parameter int N_ENTRY = 16,
  parameter int N_LINE  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [REG_AW-1:0]    reg_addr_i,
  input  logic [ENTRY_W-1:0]   reg_wdata_i,
  input  logic                 reg_we_i,
  output logic [ENTRY_W-1:0]   reg_rdata_o,
  input  logic                 msg_valid_i,
  input  logic [31:0]          msg_addr_i,
  input  logic [DATA_W-1:0]    msg_data_i,
  output logic [N_LINE-1:0]    irq_o
);
  logic [ENTRY_W-1:0] ent_q [N_ENTRY];
  logic               order_q;
  logic [N_LINE-1:0]  pend_q;
  logic [N_LINE-1:0]  hit;
  logic [N_LINE-1:0]  sel [N_ENTRY];
  logic [DATA_W-1:0]  cmp_data;
  logic [KEY_W-1:0]   key;
  logic               unused_addr;

  assign unused_addr = ^{msg_addr_i[31:24], msg_addr_i[11:0]};
  assign key      = msg_addr_i[MSG_KEY_LSB +: KEY_W];
  assign cmp_data = order_q ? {msg_data_i[7:0], msg_data_i[15:8]} : msg_data_i;

  msi_xlat_regs #(.N_ENTRY(N_ENTRY), .N_LINE(N_LINE)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .we_i    (reg_we_i),
    .hit_i   (hit),
    .ent_o   (ent_q),
    .order_o (order_q),
    .pend_o  (pend_q),
    .rdata_o (reg_rdata_o)
  );

  for (genvar ge = 0; ge < N_ENTRY; ge++) begin : g_match
    msi_entry_match #(.N_LINE(N_LINE)) u_match (
      .entry_i (ent_q[ge]),
      .valid_i (msg_valid_i),
      .key_i   (key),
      .data_i  (cmp_data),
      .line_o  (sel[ge])
    );
  end

  msi_line_merge #(.N_ENTRY(N_ENTRY), .N_LINE(N_LINE)) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .hit_o  (hit),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/msi_xlat_table_chk.sv
module msi_xlat_table_chk
  import msi_xlat_pkg::*;
#(
  parameter int N_LINE = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msg_valid_i,
  input logic               reg_we_i,
  input logic [REG_AW-1:0]  reg_addr_i,
  input logic [ENTRY_W-1:0] reg_wdata_i,
  input logic [N_LINE-1:0]  irq_o,
  input logic [N_LINE-1:0]  pend_q,
  input logic               order_q
);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_valid_i |=> irq_o == '0);

  p_irq_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~pend_q) == '0);

  p_pend_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == PEND_OFS) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_order_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ORDER_OFS) |=> order_q == $past(reg_wdata_i[0]));

  p_order_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == ORDER_OFS) |=> $stable(order_q));
endmodule

bind msi_xlat_table msi_xlat_table_chk #(.N_LINE(N_LINE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msg_valid_i (msg_valid_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .pend_q      (pend_q),
  .order_q     (order_q)
);

// File: tb/msi_xlat_table_bench.sv
`timescale 1ns/1ps
module msi_xlat_table_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_rdata_o;
  logic        msg_valid_i = 1'b0;
  logic [31:0] msg_addr_i = '0;
  logic [15:0] msg_data_i = '0;
  logic [3:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  msi_xlat_table u_msi_xlat_table (
    .clk_i, .rst_ni, .reg_addr_i, .reg_wdata_i, .reg_we_i, .reg_rdata_o,
    .msg_valid_i, .msg_addr_i, .msg_data_i, .irq_o
  );

  // reference model
  logic [31:0] m_ent [16];
  logic        m_ord;
  logic [3:0]  m_pend;
  logic [3:0]  exp_irq;

  always @(posedge clk_i or negedge rst_ni) begin : model
    logic [3:0]  h;
    logic [15:0] d;
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) m_ent[i] = 32'h8000_0000;
      m_ord = 1'b0; m_pend = '0; exp_irq = '0;
    end else begin
      h = '0;
      d = m_ord ? {msg_data_i[7:0], msg_data_i[15:8]} : msg_data_i;
      if (msg_valid_i)
        for (int i = 0; i < 16; i++)
          if (!m_ent[i][31] && m_ent[i][27:16] == msg_addr_i[23:12] && m_ent[i][15:0] == d)
            h[m_ent[i][29:28]] = 1'b1;
      exp_irq = h;
      if (reg_we_i && reg_addr_i[1:0] == 2'b00) begin
        if (reg_addr_i < 8'h40) m_ent[reg_addr_i[7:2]] = reg_wdata_i;
        else if (reg_addr_i == 8'h40) m_ord = reg_wdata_i[0];
        else if (reg_addr_i == 8'h44) m_pend = m_pend & ~reg_wdata_i[3:0];
      end
      m_pend = m_pend | h;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) chk("R4 R9 per-cycle irq_o", {28'b0, irq_o}, {28'b0, exp_irq});

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i); reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk_i); reg_addr_i = a; #1;
    chk(tag, reg_rdata_o, exp);
  endtask

  task automatic send(logic [31:0] a, logic [15:0] d, logic [3:0] exp, string tag);
    @(negedge clk_i); msg_addr_i = a; msg_data_i = d; msg_valid_i = 1'b1;
    @(negedge clk_i); msg_valid_i = 1'b0;
    chk(tag, {28'b0, irq_o}, {28'b0, exp});
  endtask

  function automatic logic [31:0] ent_val(int n, int line, logic [15:0] d);
    return (32'(line) << 28) | (32'h123 << 16) | 32'(d);
  endfunction

  initial begin : watchdog
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 irq after reset", {28'b0, irq_o}, 32'h0);
    rd(8'h00, 32'h8000_0000, "R1 entry0 reset");
    rd(8'h3C, 32'h8000_0000, "R1 entry15 reset");
    rd(8'h40, 32'h0, "R1 order reset");
    rd(8'h44, 32'h0, "R1 pending reset");

    for (int n = 0; n < 16; n++) wr(8'(4 * n), ent_val(n, n % 4, 16'(1 << n)));
    rd(8'h0C, 32'h3123_0008, "R2 entry3 readback");
    rd(8'h3C, 32'h3123_8000, "R2 entry15 readback");

    send(32'h0012_3000, 16'h0020, 4'b0010, "R4 entry5 line1");
    send(32'h0012_4000, 16'h0020, 4'b0000, "R4 address mismatch");
    send(32'h0012_3000, 16'h0003, 4'b0000, "R4 data mismatch");
    send(32'hFF12_3FFF, 16'h0020, 4'b0010, "R4 outside key bits ignored");

    wr(8'h14, 32'h8000_0000 | ent_val(5, 1, 16'h0020));
    send(32'h0012_3000, 16'h0020, 4'b0000, "R3 disabled entry5");

    wr(8'h18, ent_val(6, 2, 16'h0004));
    send(32'h0012_3000, 16'h0004, 4'b0100, "R6 two entries one line");
    wr(8'h1C, ent_val(7, 3, 16'h0001));
    send(32'h0012_3000, 16'h0001, 4'b1001, "R6 two lines together");

    rd(8'h44, 32'hF, "R7 pending set");
    wr(8'h44, 32'h0);
    rd(8'h44, 32'hF, "R7 write zero keeps");
    wr(8'h44, 32'h1);
    rd(8'h44, 32'hE, "R7 clear bit0");
    wr(8'h44, 32'hF);
    rd(8'h44, 32'h0, "R7 clear all");

    wr(8'h40, 32'h1);
    rd(8'h40, 32'h1, "R5 order readback");
    send(32'h0012_3000, 16'h0100, 4'b1001, "R5 swapped to 0x0001");
    send(32'h0012_3000, 16'h0001, 4'b0001, "R5 swapped to 0x0100");
    wr(8'h40, 32'hFFFF_FFFE);
    rd(8'h40, 32'h0, "R5 order back to 0");
    send(32'h0012_3000, 16'h0100, 4'b0001, "R5 unswapped entry8");

    // hit and clear in one cycle
    @(negedge clk_i);
    msg_addr_i = 32'h0012_3000; msg_data_i = 16'h0002; msg_valid_i = 1'b1;
    reg_addr_i = 8'h44; reg_wdata_i = 32'hF; reg_we_i = 1'b1;
    @(negedge clk_i); msg_valid_i = 1'b0; reg_we_i = 1'b0;
    chk("R7 pulse during clear", {28'b0, irq_o}, 32'h2);
    rd(8'h44, 32'h2, "R7 set wins over clear");

    wr(8'h01, 32'h0);
    rd(8'h00, 32'h0123_0001, "R8 unaligned write ignored");
    rd(8'h01, 32'h0, "R8 unaligned read zero");
    wr(8'h41, 32'h1);
    rd(8'h40, 32'h0, "R8 unaligned order write ignored");
    wr(8'h48, 32'hFFFF_FFFF);
    rd(8'h48, 32'h0, "R8 unmapped 0x48 read zero");
    rd(8'h80, 32'h0, "R8 unmapped 0x80 read zero");
    rd(8'h44, 32'h2, "R8 pending untouched");

    // table write and message in one cycle
    @(negedge clk_i);
    msg_addr_i = 32'h0012_3000; msg_data_i = 16'h0200; msg_valid_i = 1'b1;
    reg_addr_i = 8'h24; reg_wdata_i = 32'h8000_0000; reg_we_i = 1'b1;
    @(negedge clk_i); msg_valid_i = 1'b0; reg_we_i = 1'b0;
    chk("R10 old table used", {28'b0, irq_o}, 32'h2);
    send(32'h0012_3000, 16'h0200, 4'b0000, "R10 new table used");
    rd(8'h24, 32'h8000_0000, "R2 entry9 readback");

    repeat (3) @(negedge clk_i);
    chk("R9 idle quiet", {28'b0, irq_o}, 32'h0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule